// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Arbiter

This block looks at a bank of interrupt sources and, separately for each processor, finds the most urgent source that is enabled and pending for that processor. A smaller priority value is more urgent. The winner is then tested against two limits for that processor. The first is its priority mask: the winner is reported as the processor's top pending ID only if its priority is at or below the mask. The second is the priority of the interrupt the processor is already servicing: the request line goes high only if the winner is strictly more urgent than that running priority.

The block sits between the interrupt state storage and the processor request pins. Enable bits, pending bits, priorities, masks and running priorities all arrive as plain level inputs. The two results are registered, so each output reflects the inputs one clock cycle after they are sampled. A running priority of 0x100 means the processor is idle. After reset the usual settings are a mask of 0xF0 and a running priority of 0x100, and they are driven from outside the block. For the low source IDs, below BANKED, each processor has its own priority. Every higher ID has a single priority shared by all processors.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among the candidates of a processor, the one with the numerically smallest priority value is selected.
- R2: A source is a candidate for processor c only when src_en[s] is set and src_pend[c*NUM_SRC+s] is set; a source that is pending for one processor does not affect another.
- R3: When a processor has no candidate, its top_id is 1023 and its irq_req is low.
- R4: The winner's ID is reported on top_id only if its priority is less than or equal to that processor's mask; a mask equal to the priority passes, and a larger priority gives 1023 with irq_req low.
- R5: irq_req is high only if the winner passes the mask and its priority is strictly less than the processor's running priority; equal values leave irq_req low while top_id still shows the winner.
- R6: When glb_en is low, or cpu_en[c] is low, processor c shows top_id 1023 and irq_req low, whatever the sources do.
- R7: For source s < BANKED, the priority for processor c is prio_local[(c*BANKED+s)*8 +: 8]; for s >= BANKED it is prio_common[(s-BANKED)*8 +: 8], shared by all processors.
- R8: When candidates tie on priority, the lowest source ID wins.
- R9: While rst_n is low, every top_id is 1023 and every irq_req is low; afterwards the outputs follow input changes exactly one clock later.
- R10: A running priority of 0x100 (idle) lets any winner that passes the mask raise irq_req, including priority 0xFF under mask 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for distribution |
| cpu_en | input | NUM_CPU | Enable for each processor's interface |
| src_en | input | NUM_SRC | Enable bit for each source |
| src_pend | input | NUM_CPU*NUM_SRC | Pending bits, bit c*NUM_SRC+s for source s on processor c |
| prio_local | input | NUM_CPU*BANKED*PRIO_W | Priorities for each processor and each low source ID |
| prio_common | input | (NUM_SRC-BANKED)*PRIO_W | Shared priorities for the higher source IDs |
| prio_mask | input | NUM_CPU*PRIO_W | Priority mask for each processor |
| run_prio | input | NUM_CPU*(PRIO_W+1) | Running priority for each processor, 0x100 when idle |
| top_id | output | NUM_CPU*ID_W | Top pending ID for each processor, 1023 when there is none |
| irq_req | output | NUM_CPU | Interrupt request line for each processor |

## Verification
The case that is hardest to reach from the ports is two limits meeting at once. In it, the winner passes the mask exactly at equality while its priority equals the running priority, so top_id shows the winner and irq_req stays low. It sits beside the mirror case, where a priority one step lower raises the line. The vector table sets up each such pair of competing sources with exact priorities, masks and running priorities. The same table also covers ties at both ends of the ID range and a winner from the shared range. Directed tests then split banked priorities between processors, and turn off each enable on its own. A final test shows that a change reaches the outputs only after one clock edge.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int unsigned PIA_ID_W    = 10;
  localparam int unsigned PIA_PRIO_W  = 8;
  localparam logic [PIA_ID_W-1:0] PIA_NONE_ID = '1;
endpackage

// File: rtl/pia_leaf_build.sv
module pia_leaf_build #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned BANKED  = 32,
  parameter int unsigned PRIO_W  = pia_pkg::PIA_PRIO_W,
  parameter int unsigned CPU_IDX = 0,
  localparam int unsigned KEY_W  = PRIO_W + 1
) (
  input  logic [NUM_SRC-1:0]                 src_en,
  input  logic [NUM_SRC-1:0]                 pend_row,
  input  logic [NUM_CPU*BANKED*PRIO_W-1:0]   prio_local,
  input  logic [(NUM_SRC-BANKED)*PRIO_W-1:0] prio_common,
  output logic [NUM_SRC*KEY_W-1:0]           keys
);
  localparam logic [KEY_W-1:0] IDLE_KEY = {1'b1, {PRIO_W{1'b0}}};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [PRIO_W-1:0] prio;
    if (s < BANKED) begin : g_bank
      assign prio = prio_local[(CPU_IDX*BANKED+s)*PRIO_W +: PRIO_W];
    end else begin : g_shared
      assign prio = prio_common[(s-BANKED)*PRIO_W +: PRIO_W];
    end
    assign keys[s*KEY_W +: KEY_W] = (src_en[s] && pend_row[s]) ? {1'b0, prio} : IDLE_KEY;
  end
endmodule

// File: rtl/pia_min_tree.sv
module pia_min_tree #(
  parameter int unsigned N      = 64,
  parameter int unsigned KEY_W  = 9,
  parameter int unsigned ID_W   = pia_pkg::PIA_ID_W,
  localparam int unsigned DEPTH  = (N > 1) ? $clog2(N) : 0,
  localparam int unsigned LEAVES = 1 << DEPTH
) (
  input  logic [N*KEY_W-1:0] keys,
  output logic [KEY_W-1:0]   best_key,
  output logic [ID_W-1:0]    best_id
);
  localparam logic [KEY_W-1:0] IDLE_KEY = {1'b1, {(KEY_W-1){1'b0}}};

  for (genvar l = 0; l <= DEPTH; l++) begin : lvl
    localparam int unsigned W = LEAVES >> l;
    logic [KEY_W-1:0] k  [W];
    logic [ID_W-1:0]  id [W];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_j
        if (j < N) begin : g_real
          assign k[j]  = keys[j*KEY_W +: KEY_W];
          assign id[j] = ID_W'(j);
        end else begin : g_pad
          assign k[j]  = IDLE_KEY;
          assign id[j] = pia_pkg::PIA_NONE_ID;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_j
        logic take_hi;
        // the lower-ID half keeps the slot unless the upper half is strictly smaller
        assign take_hi = lvl[l-1].k[2*j+1] < lvl[l-1].k[2*j];
        assign k[j]    = take_hi ? lvl[l-1].k[2*j+1]  : lvl[l-1].k[2*j];
        assign id[j]   = take_hi ? lvl[l-1].id[2*j+1] : lvl[l-1].id[2*j];
      end
    end
  end

  assign best_key = lvl[DEPTH].k[0];
  assign best_id  = lvl[DEPTH].id[0];
endmodule

// File: rtl/pia_gate.sv
module pia_gate #(
  parameter int unsigned PRIO_W = pia_pkg::PIA_PRIO_W,
  parameter int unsigned ID_W   = pia_pkg::PIA_ID_W,
  localparam int unsigned KEY_W = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on,
  input  logic [KEY_W-1:0]  best_key,
  input  logic [ID_W-1:0]   best_id,
  input  logic [PRIO_W-1:0] mask,
  input  logic [KEY_W-1:0]  run,
  output logic [ID_W-1:0]   id_q,
  output logic              req_q
);
  logic found, pass_mask, beats_run, shown;

  assign found     = ~best_key[KEY_W-1];
  assign pass_mask = best_key <= {1'b0, mask};
  assign beats_run = best_key < run;
  assign shown     = on && found && pass_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= pia_pkg::PIA_NONE_ID;
      req_q <= 1'b0;
    end else begin
      id_q  <= shown ? best_id : pia_pkg::PIA_NONE_ID;
      req_q <= shown && beats_run;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned BANKED  = 32,
  parameter int unsigned PRIO_W  = pia_pkg::PIA_PRIO_W,
  parameter int unsigned ID_W    = pia_pkg::PIA_ID_W,
  localparam int unsigned KEY_W  = PRIO_W + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              glb_en,
  input  logic [NUM_CPU-1:0]                cpu_en,
  input  logic [NUM_SRC-1:0]                src_en,
  input  logic [NUM_CPU*NUM_SRC-1:0]        src_pend,
  input  logic [NUM_CPU*BANKED*PRIO_W-1:0]  prio_local,
  input  logic [(NUM_SRC-BANKED)*PRIO_W-1:0] prio_common,
  input  logic [NUM_CPU*PRIO_W-1:0]         prio_mask,
  input  logic [NUM_CPU*KEY_W-1:0]          run_prio,
  output logic [NUM_CPU*ID_W-1:0]           top_id,
  output logic [NUM_CPU-1:0]                irq_req
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC*KEY_W-1:0] keys;
    logic [KEY_W-1:0]         best_key;
    logic [ID_W-1:0]          best_id;

    pia_leaf_build #(
      .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .BANKED(BANKED),
      .PRIO_W(PRIO_W), .CPU_IDX(c)
    ) u_leaf (
      .src_en     (src_en),
      .pend_row   (src_pend[c*NUM_SRC +: NUM_SRC]),
      .prio_local (prio_local),
      .prio_common(prio_common),
      .keys       (keys)
    );

    pia_min_tree #(.N(NUM_SRC), .KEY_W(KEY_W), .ID_W(ID_W)) u_tree (
      .keys    (keys),
      .best_key(best_key),
      .best_id (best_id)
    );

    pia_gate #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .on      (glb_en && cpu_en[c]),
      .best_key(best_key),
      .best_id (best_id),
      .mask    (prio_mask[c*PRIO_W +: PRIO_W]),
      .run     (run_prio[c*KEY_W +: KEY_W]),
      .id_q    (top_id[c*ID_W +: ID_W]),
      .req_q   (irq_req[c])
    );
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned BANKED  = 32,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned ID_W    = 10,
  localparam int unsigned KEY_W  = PRIO_W + 1,
  localparam int unsigned SW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              glb_en,
  input logic [NUM_CPU-1:0]                cpu_en,
  input logic [NUM_SRC-1:0]                src_en,
  input logic [NUM_CPU*NUM_SRC-1:0]        src_pend,
  input logic [NUM_CPU*BANKED*PRIO_W-1:0]  prio_local,
  input logic [(NUM_SRC-BANKED)*PRIO_W-1:0] prio_common,
  input logic [NUM_CPU*PRIO_W-1:0]         prio_mask,
  input logic [NUM_CPU*KEY_W-1:0]          run_prio,
  input logic [NUM_CPU*ID_W-1:0]           top_id,
  input logic [NUM_CPU-1:0]                irq_req
);
  localparam logic [ID_W-1:0] NONE = '1;

  logic [NUM_SRC-1:0]         en_q;
  logic [NUM_CPU*NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk) begin
    en_q   <= src_en;
    pend_q <= src_pend;
  end

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      assert_reset_quiet_R9: assert (irq_req == '0 && top_id == {NUM_CPU{NONE}});
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    logic [ID_W-1:0] idc;
    assign idc = top_id[c*ID_W +: ID_W];

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en || !cpu_en[c]) |=> (!irq_req[c] && idc == NONE));

    assert_none_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pend[c*NUM_SRC +: NUM_SRC] == '0) |=> (!irq_req[c] && idc == NONE));

    assert_req_has_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> (idc != NONE));

    assert_id_is_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idc != NONE) |-> (idc < ID_W'(NUM_SRC) && en_q[idc[SW-1:0]]
                         && pend_q[c*NUM_SRC + int'(idc[SW-1:0])]));
  end
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .BANKED(BANKED),
  .PRIO_W(PRIO_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/sim_irq_prio_arbiter.sv
module sim_irq_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 64, NC = 2, NB = 32, PW = 8, IW = 10;
  localparam int NONE = 1023;

  typedef struct packed {
    logic [7:0] a; logic [7:0] pa; logic [7:0] b; logic [7:0] pb;
    logic [7:0] mask; logic [8:0] run; logic [9:0] id; logic irq;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'd5,  8'h40, 8'd40, 8'h30, 8'hF0, 9'h100, 10'd40,  1'b1},
    '{8'd5,  8'h20, 8'd40, 8'h30, 8'hF0, 9'h100, 10'd5,   1'b1},
    '{8'd10, 8'h50, 8'd20, 8'h50, 8'hF0, 9'h100, 10'd10,  1'b1},
    '{8'd50, 8'h60, 8'd33, 8'h60, 8'hF0, 9'h100, 10'd33,  1'b1},
    '{8'd7,  8'hF0, 8'd8,  8'hF8, 8'hF0, 9'h100, 10'd7,   1'b1},
    '{8'd7,  8'hF1, 8'd8,  8'hF8, 8'hF0, 9'h100, 10'd1023,1'b0},
    '{8'd12, 8'h40, 8'd60, 8'h90, 8'hFF, 9'h040, 10'd12,  1'b0},
    '{8'd12, 8'h3F, 8'd60, 8'h90, 8'hFF, 9'h040, 10'd12,  1'b1},
    '{8'd63, 8'hFF, 8'd0,  8'hFF, 8'hFF, 9'h100, 10'd0,   1'b1},
    '{8'd63, 8'hFF, 8'd62, 8'hFE, 8'hFF, 9'h100, 10'd62,  1'b1},
    '{8'd3,  8'h00, 8'd4,  8'h00, 8'h00, 9'h001, 10'd3,   1'b1},
    '{8'd3,  8'h00, 8'd4,  8'h00, 8'h00, 9'h000, 10'd3,   1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic glb_en;
  logic [NC-1:0] cpu_en;
  logic [NS-1:0] src_en;
  logic [NC*NS-1:0] src_pend;
  logic [NC*NB*PW-1:0] prio_local;
  logic [(NS-NB)*PW-1:0] prio_common;
  logic [NC*PW-1:0] prio_mask;
  logic [NC*(PW+1)-1:0] run_prio;
  logic [NC*IW-1:0] top_id;
  logic [NC-1:0] irq_req;

  int checks = 0, errors = 0;
  bit done = 0;

  irq_prio_arbiter u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic set_prio(input int c, input int s, input logic [7:0] p);
    if (s < NB) prio_local[(c*NB+s)*PW +: PW] = p;
    else prio_common[(s-NB)*PW +: PW] = p;
  endtask

  task automatic clear_all();
    glb_en = 1'b1; cpu_en = '1; src_en = '0; src_pend = '0;
    prio_local = {NC*NB{8'h80}}; prio_common = {(NS-NB){8'h80}};
    prio_mask = {NC{8'hF0}}; run_prio = {NC{9'h100}};
  endtask

  // independent scan of the sources for processor c
  task automatic ref_eval(input int c, output int id, output int irq);
    int best = 256, bid = NONE;
    for (int s = 0; s < NS; s++) begin
      int p;
      if (src_en[s] && src_pend[c*NS+s]) begin
        p = (s < NB) ? int'(prio_local[(c*NB+s)*PW +: PW]) : int'(prio_common[(s-NB)*PW +: PW]);
        if (p < best) begin best = p; bid = s; end
      end
    end
    if (glb_en && cpu_en[c] && best <= int'(prio_mask[c*PW +: PW])) begin
      id = bid;
      irq = (best < int'(run_prio[c*(PW+1) +: PW+1])) ? 1 : 0;
    end else begin
      id = NONE; irq = 0;
    end
  endtask

  function automatic int gid(input int c);
    return int'(top_id[c*IW +: IW]);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cmp_ref(input string tag, input int c);
    int id, irq;
    ref_eval(c, id, irq);
    chk($sformatf("%s cpu%0d id", tag, c), gid(c), id);
    chk($sformatf("%s cpu%0d irq", tag, c), int'(irq_req[c]), irq);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_all();
    src_en = '1; src_pend = '1;
    repeat (3) @(posedge clk); #1;
    // R9: outputs idle during reset even with everything pending
    chk("R9 reset cpu0 id", gid(0), NONE);
    chk("R9 reset cpu1 id", gid(1), NONE);
    chk("R9 reset irq", int'(irq_req), 0);
    @(negedge clk); rst_n = 1'b1;

    // table: two competing sources pending on cpu0 only (R1 R4 R5 R7 R8 R10)
    foreach (VEC[i]) begin
      @(negedge clk);
      clear_all();
      src_en[VEC[i].a] = 1'b1; src_en[VEC[i].b] = 1'b1;
      src_pend[VEC[i].a] = 1'b1; src_pend[VEC[i].b] = 1'b1;
      set_prio(0, VEC[i].a, VEC[i].pa);
      set_prio(0, VEC[i].b, VEC[i].pb);
      prio_mask[0 +: PW] = VEC[i].mask;
      run_prio[0 +: PW+1] = VEC[i].run;
      step();
      chk($sformatf("R1 R4 R5 R8 R10 vec%0d cpu0 id", i), gid(0), int'(VEC[i].id));
      chk($sformatf("R5 R10 vec%0d cpu0 irq", i), int'(irq_req[0]), int'(VEC[i].irq));
      cmp_ref($sformatf("R2 vec%0d", i), 1);
    end

    // R2: disabled pending source is not a candidate; pending on cpu1 only
    @(negedge clk); clear_all();
    src_pend[9] = 1'b1;                 // cpu0, source 9, not enabled
    src_en[45] = 1'b1; src_pend[NS+45] = 1'b1; // cpu1 only
    step();
    chk("R2 disabled src cpu0 id", gid(0), NONE);
    chk("R2 other cpu cpu1 id", gid(1), 45);
    chk("R2 other cpu cpu1 irq", int'(irq_req[1]), 1);

    // R7: banked priority differs per processor, shared one does not
    @(negedge clk); clear_all();
    src_en[5] = 1'b1; src_en[40] = 1'b1;
    src_pend[5] = 1'b1; src_pend[40] = 1'b1; src_pend[NS+5] = 1'b1; src_pend[NS+40] = 1'b1;
    set_prio(0, 5, 8'h10); set_prio(1, 5, 8'h90); set_prio(0, 40, 8'h50);
    step();
    chk("R7 banked cpu0 id", gid(0), 5);
    chk("R7 shared cpu1 id", gid(1), 40);
    cmp_ref("R7", 0); cmp_ref("R7", 1);

    // R6: processor enable off only affects that processor
    @(negedge clk); cpu_en[1] = 1'b0;
    step();
    chk("R6 cpu1 off id", gid(1), NONE);
    chk("R6 cpu1 off irq", int'(irq_req[1]), 0);
    chk("R6 cpu0 still id", gid(0), 5);
    // R6: global enable off silences all
    @(negedge clk); cpu_en = '1; glb_en = 1'b0;
    step();
    chk("R6 global off id0", gid(0), NONE);
    chk("R6 global off id1", gid(1), NONE);
    chk("R6 global off irq", int'(irq_req), 0);

    // R3: nothing pending
    @(negedge clk); clear_all(); src_en = '1;
    step();
    cmp_ref("R3", 0);
    chk("R3 none cpu1 id", gid(1), NONE);

    // R9: one-cycle latency
    @(negedge clk); src_pend[NS+17] = 1'b1;
    #1;
    chk("R9 before edge cpu1 id", gid(1), NONE);
    step();
    chk("R9 after edge cpu1 id", gid(1), 17);
    chk("R9 after edge cpu1 irq", int'(irq_req[1]), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule